// File: doc/BRIEF.md
# Supply-Loss Bus Guard Sequencer

This block sits between a host bus and a battery-backed memory and decides, from two digitised supply-monitor levels, when the memory may be accessed. One level says the main rail has fallen below the deselect threshold. The other says the rail has fallen below the battery switchover point. Both levels arrive asynchronously. Each passes through a two-flop synchroniser and is then sampled once per fixed sampling period. The sampling period bounds how late protection can be applied after a fast supply collapse. A spike that happens to be present at a sampling instant is treated as a real failure.

Protection works differently on the way down and on the way up. A sampled low rail inhibits the bus on the next clock. At that moment the chip-select, write strobe and data-output enable toward the memory are all forced inactive, so a write in flight is cut short and can damage only the byte it addresses. When the rail is sampled good again, the inhibit stays on until a number of reference ticks has been counted. With a 1 ms tick the default count is 100, which lies inside the required 40 to 200 ms window. Any low sample during that count restarts the protected state. A sampled rail below the switchover point selects the battery. Reset puts the block in the protected, battery-selected state.

Top module: `pfs_sequencer`

## Requirements
- R1: While reset is held, and after it is released until the first good-supply sample has been processed, inhibit_o is 1, bat_sel_o is 1, and mem_ce_o, mem_we_o and dq_oe_o are 0.
- R2: While inhibit_o is 1, mem_ce_o, mem_we_o and dq_oe_o are 0 whatever the values of bus_ce_i, bus_we_i and bus_oe_i.
- R3: While inhibit_o is 0, mem_ce_o equals bus_ce_i, mem_we_o equals bus_ce_i AND bus_we_i, and dq_oe_o equals bus_ce_i AND bus_oe_i AND NOT bus_we_i, so a write strobe always turns the outputs off.
- R4: The two supply levels are taken only at sampling instants, one every SAMPLE_CYC clocks. A low deselect level held for at least SAMPLE_CYC+2 clocks, including a brief spike of that length, raises inhibit_o within SAMPLE_CYC+5 clocks of its start.
- R5: Protection entry is immediate: the clock after a low deselect sample, inhibit_o is 1 and mem_we_o is 0, ending any write in progress.
- R6: The clock after a sample that shows the rail below switchover, bat_sel_o is 1. A sample that shows it above switchover returns bat_sel_o to 0 while inhibit_o can still be 1.
- R7: After the rail is sampled good, inhibit_o stays 1 until REC_TICKS pulses of tick_i have been counted. It then falls to 0.
- R8: A low deselect sample during the recovery count sends the block back to the protected state and clears the count, so a full REC_TICKS ticks are needed again after the next good sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock reference pulse that paces the recovery count |
| pf_low_i | input | 1 | Asynchronous level: rail below deselect threshold |
| so_low_i | input | 1 | Asynchronous level: rail below battery switchover threshold |
| bus_ce_i | input | 1 | Host chip select, active high |
| bus_we_i | input | 1 | Host write strobe, active high |
| bus_oe_i | input | 1 | Host output enable, active high |
| mem_ce_o | output | 1 | Gated chip select toward the memory |
| mem_we_o | output | 1 | Gated write strobe toward the memory |
| dq_oe_o | output | 1 | Data-bus tri-state enable, 1 = drive |
| inhibit_o | output | 1 | Deselect / write-inhibit indication |
| bat_sel_o | output | 1 | 1 = power from battery, 0 = main rail |

## Verification
The assertions assume that tick_i is a single-clock pulse and that the two supply levels are consistent, which means a below-switchover level never comes with a good deselect level. The bench always raises so_low_i only while pf_low_i is already low, and drops pf_low_i only after so_low_i has cleared. Supply changes and spikes last several clocks, so every change is caught by at least one sampling instant. The bench generates ticks on a fixed period, which lets it compute windows for the recovery time and the restart case without knowing the sampling phase.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        PW_BATT  = 2'd0,
        PW_HOLD  = 2'd1,
        PW_RECOV = 2'd2,
        PW_LIVE  = 2'd3
    } pw_state_e;

    typedef struct packed {
        logic pf_low;
        logic so_low;
    } rail_lvl_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = async_i;
        r_d.stab = r_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.meta <= RST_VAL;
            r_q.stab <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o = r_q.stab;

endmodule

// File: rtl/pfs_sampler.sv
module pfs_sampler
    import pfs_pkg::*;
#(
    parameter int SAMPLE_CYC = 20000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  rail_lvl_t lvl_i,
    output logic      strobe_o,
    output rail_lvl_t lvl_o
);

    localparam int CW = (SAMPLE_CYC > 2) ? $clog2(SAMPLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        rail_lvl_t     held;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        strobe_o = (s_q.cnt == LAST);
        if (strobe_o) begin
            s_d.cnt  = '0;
            s_d.held = lvl_i;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.held <= '{pf_low: 1'b1, so_low: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o = s_q.held;

    // R4: sampled levels only move at a sampling instant
    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |=> $stable(lvl_o));

endmodule

// File: rtl/pfs_recovery.sv
module pfs_recovery #(
    parameter int REC_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int CW = $clog2(REC_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(REC_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rec_t;

    rec_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!en_i) begin
            c_d.cnt = '0;
        end else if (tick_i && (c_q.cnt != FULL)) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign done_o = (c_q.cnt == FULL);

    // R8: leaving recovery discards the partial count
    assert_count_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !done_o);

endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer
    import pfs_pkg::*;
#(
    parameter int SAMPLE_CYC = 20000,
    parameter int REC_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pf_low_i,
    input  logic so_low_i,
    input  logic bus_ce_i,
    input  logic bus_we_i,
    input  logic bus_oe_i,
    output logic mem_ce_o,
    output logic mem_we_o,
    output logic dq_oe_o,
    output logic inhibit_o,
    output logic bat_sel_o
);

    rail_lvl_t raw_lvl, sync_lvl, smp_lvl;
    logic      smp_strobe;
    logic      rec_en, rec_done;

    typedef struct packed {
        pw_state_e st;
    } seq_t;

    seq_t q_d, q_q;

    assign raw_lvl = '{pf_low: pf_low_i, so_low: so_low_i};

    pfs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lvl),
        .sync_o  (sync_lvl)
    );

    pfs_sampler #(.SAMPLE_CYC(SAMPLE_CYC)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (sync_lvl),
        .strobe_o (smp_strobe),
        .lvl_o    (smp_lvl)
    );

    pfs_recovery #(.REC_TICKS(REC_TICKS)) u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rec_en),
        .tick_i (tick_i),
        .done_o (rec_done)
    );

    assign rec_en = (q_q.st == PW_RECOV);

    always_comb begin
        q_d = q_q;
        if (smp_lvl.so_low) begin
            q_d.st = PW_BATT;
        end else if (smp_lvl.pf_low) begin
            q_d.st = PW_HOLD;
        end else begin
            unique case (q_q.st)
                PW_BATT, PW_HOLD: q_d.st = PW_RECOV;
                PW_RECOV:         q_d.st = rec_done ? PW_LIVE : PW_RECOV;
                default:          q_d.st = PW_LIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q.st <= PW_BATT;
        else        q_q    <= q_d;
    end

    logic live;
    assign live      = (q_q.st == PW_LIVE);
    assign inhibit_o = !live;
    assign bat_sel_o = (q_q.st == PW_BATT);
    assign mem_ce_o  = live && bus_ce_i;
    assign mem_we_o  = live && bus_ce_i && bus_we_i;
    assign dq_oe_o   = live && bus_ce_i && bus_oe_i && !bus_we_i;

    // R5: a low deselect sample blocks the bus on the very next clock
    assert_entry_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_lvl.pf_low && !inhibit_o) |=> (inhibit_o && !mem_we_o));

    // R6: a below-switchover sample selects the battery
    assert_battery_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_lvl.so_low |=> bat_sel_o);

    // R7: bus access is only re-enabled once the recovery count is complete
    assert_release_after_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inhibit_o) |-> $past(rec_done));

endmodule

// File: tb/test_pfs_sequencer.sv
module test_pfs_sequencer;

    localparam int SAMPLE_CYC = 8;
    localparam int REC_TICKS  = 5;
    localparam int TICK_PER   = 10;
    localparam int ENTRY_MAX  = SAMPLE_CYC + 5;
    localparam int REC_MIN    = (REC_TICKS - 1) * TICK_PER;
    localparam int REC_MAX    = SAMPLE_CYC + 6 + (REC_TICKS + 1) * TICK_PER;

    // {ce, we, oe, exp_ce, exp_we, exp_oe} when the bus is live
    localparam logic [5:0] VEC [8] = '{
        6'b000_000, 6'b001_000, 6'b010_000, 6'b011_000,
        6'b100_100, 6'b101_101, 6'b110_110, 6'b111_110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic pf_low_i = 1'b1, so_low_i = 1'b1;
    logic bus_ce_i = 1'b0, bus_we_i = 1'b0, bus_oe_i = 1'b0;
    logic mem_ce_o, mem_we_o, dq_oe_o, inhibit_o, bat_sel_o;

    int n_chk = 0;
    int n_bad = 0;
    int tcnt  = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (tcnt == TICK_PER - 1) begin
            tcnt   <= 0;
            tick_i <= 1'b1;
        end else begin
            tcnt   <= tcnt + 1;
            tick_i <= 1'b0;
        end
    end

    pfs_sequencer #(.SAMPLE_CYC(SAMPLE_CYC), .REC_TICKS(REC_TICKS)) i_pfs_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .pf_low_i  (pf_low_i),
        .so_low_i  (so_low_i),
        .bus_ce_i  (bus_ce_i),
        .bus_we_i  (bus_we_i),
        .bus_oe_i  (bus_oe_i),
        .mem_ce_o  (mem_ce_o),
        .mem_we_o  (mem_we_o),
        .dq_oe_o   (dq_oe_o),
        .inhibit_o (inhibit_o),
        .bat_sel_o (bat_sel_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_inhibit(input logic val, input int limit, output int n);
        n = 0;
        while (inhibit_o !== val && n <= limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic walk_table(input string req, input logic live);
        for (int i = 0; i < 8; i++) begin
            {bus_ce_i, bus_we_i, bus_oe_i} = VEC[i][5:3];
            #1;
            chk(req, int'({mem_ce_o, mem_we_o, dq_oe_o}), live ? int'(VEC[i][2:0]) : 0);
        end
    endtask

    initial begin
        int n;
        bus_ce_i = 1'b1; bus_we_i = 1'b1; bus_oe_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state with all bus inputs active
        chk("R1 inhibit in reset", int'(inhibit_o), 1);
        chk("R1 battery in reset", int'(bat_sel_o), 1);
        chk("R1 gated outputs in reset", int'({mem_ce_o, mem_we_o, dq_oe_o}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 still protected after release", int'(inhibit_o), 1);

        // R6 / R7: rail good, battery released, recovery timed
        pf_low_i = 1'b0; so_low_i = 1'b0;
        repeat (SAMPLE_CYC + 6) @(negedge clk);
        chk("R6 main rail after recovery of switchover", int'(bat_sel_o), 0);
        chk("R7 still inhibited early in recovery", int'(inhibit_o), 1);
        wait_inhibit(1'b0, 200, n);
        chk_range("R7 recovery length", n + SAMPLE_CYC + 6, REC_MIN, REC_MAX);

        // R3: live gating
        walk_table("R3 live gating", 1'b1);

        // R5 / R4: write in flight cut by power fail
        bus_ce_i = 1'b1; bus_we_i = 1'b1; bus_oe_i = 1'b0;
        @(negedge clk);
        chk("R3 write passes while live", int'(mem_we_o), 1);
        pf_low_i = 1'b1;
        wait_inhibit(1'b1, 50, n);
        chk_range("R4 deselect latency", n, 1, ENTRY_MAX);
        chk("R5 write strobe cut", int'(mem_we_o), 0);
        chk("R6 stays on main rail above switchover", int'(bat_sel_o), 0);

        // R2: inhibited gating
        walk_table("R2 inhibited gating", 1'b0);

        // R6: battery switchover and return
        so_low_i = 1'b1;
        repeat (ENTRY_MAX) @(negedge clk);
        chk("R6 battery selected", int'(bat_sel_o), 1);
        so_low_i = 1'b0;
        repeat (ENTRY_MAX) @(negedge clk);
        chk("R6 back to main rail", int'(bat_sel_o), 0);
        chk("R6 still inhibited after return", int'(inhibit_o), 1);

        // R8: low sample mid-recovery restarts the count
        pf_low_i = 1'b0;
        repeat (SAMPLE_CYC + 20) @(negedge clk);
        chk("R8 recovering before glitch", int'(inhibit_o), 1);
        pf_low_i = 1'b1;
        repeat (SAMPLE_CYC + 2) @(negedge clk);
        pf_low_i = 1'b0;
        wait_inhibit(1'b0, 200, n);
        chk_range("R8 full count after restart", n, REC_MIN, REC_MAX);

        // R4: a spike while live is taken as a failure
        bus_ce_i = 1'b1; bus_we_i = 1'b0; bus_oe_i = 1'b1;
        @(negedge clk);
        chk("R3 read enable while live", int'(dq_oe_o), 1);
        pf_low_i = 1'b1;
        repeat (SAMPLE_CYC + 2) @(negedge clk);
        pf_low_i = 1'b0;
        n = 0;
        while (inhibit_o !== 1'b1 && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R4 spike raises inhibit", int'(inhibit_o), 1);
        chk("R2 outputs off after spike", int'(dq_oe_o), 0);
        wait_inhibit(1'b0, 200, n);
        chk("R7 recovers after spike", int'(inhibit_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule